// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes a set of external interrupt lines (24 by default) to processors as interrupt messages. Each input owns a 64-bit routing entry. The entry holds the vector, the delivery mode, the destination and its addressing mode, the input polarity, the trigger type and a mask. Software never addresses an entry directly. It first writes an 8-bit selector at offset 00h and then reads or writes a 32-bit window at offset 10h. Each entry takes two selector values: the even one carries the lower half and the odd one carries the upper half. Three identification words sit at the bottom of the selector space.

The raw lines are registered once, corrected for polarity, and then handled in one of two ways. Edge inputs raise a request on each inactive-to-active transition. Level inputs request for as long as they are active. Requests collect in per-entry pending flags. The lowest-numbered pending entry is latched into a message slot, and the slot is offered on a valid/ready port. A level entry that has been delivered is blocked by its remote-request flag. That flag clears only when an end-of-interrupt arrives carrying the entry's vector.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset the selector reads 00h, the ID word reads 0000_0000h, every entry's lower half reads 0001_0000h (masked), every upper half reads 0, and no message is offered.
- R2: A write to offset 00h with byte enable 0 set loads the 8-bit selector, which reads back at offset 00h in bits 7:0. Offset 10h is the data window for the selected word.
- R3: A window write with any byte enable clear changes nothing.
- R4: Selector 00h is the ID word: bits 27:24 are writable and all other bits read 0. Selector 01h reads 0017_0011h and selector 02h reads 0000_0000h, and writes to either have no effect.
- R5: Selector 10h+2n is the lower half of entry n and 10h+2n+1 is its upper half. The lower half has vector at 7:0, delivery mode at 10:8, destination mode at 11, delivery status at 12, polarity at 13 (1 = active low), remote request at 14, trigger at 15 (1 = level) and mask at 16. The upper half has the destination at 31:24. Bits 12 and 14 ignore writes, and all other bits read 0.
- R6: Selectors at and above 10h+2×entries read 0, and writes to them change no entry.
- R7: An unmasked edge entry raises exactly one message per inactive-to-active transition. A line that stays active raises no further message.
- R8: With polarity 1, a high-to-low transition of the line is the active edge.
- R9: An edge that arrives while its entry is masked is discarded and is not delivered when the mask is later cleared.
- R10: A level entry is delivered once and then sets remote request (bit 14). It is not delivered again until an end-of-interrupt carries its vector. An end-of-interrupt with any other vector does not clear the flag. If the line is still active after the matching end-of-interrupt, the entry is delivered again.
- R11: Delivery status (bit 12) reads 1 while the entry's message waits on the port and reads 0 once the port has accepted it.
- R12: When several entries are pending, the lowest-numbered one is offered first. An offered message keeps valid high and its fields unchanged until ready is seen.
- R13: The message carries the entry's vector, destination, destination mode, delivery mode and trigger type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset: 00h selector, 10h window |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | 24 | Raw interrupt lines |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the message this cycle |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dest | output | 8 | Destination field |
| msg_dest_logical | output | 1 | 1 = destination is a processor set |
| msg_deliv_mode | output | 3 | Delivery mode code |
| msg_level | output | 1 | 1 = message comes from a level entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
Three kinds of bad internal state show up quickly at the ports. A stuck or wrongly cleared pending flag shows as a missing, extra or repeated message within about three cycles of the line change. It also shows at once in bit 12 of a window read. A remote-request flag in the wrong state shows as a level entry that repeats before end-of-interrupt, or that never returns after the matching vector. A fault in selector decoding or field packing shows on the very next window read as a wrong word, or as a message whose fields do not match what was written.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam logic [7:0] SEL_ID      = 8'h00;
    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_ARB     = 8'h02;
    localparam logic [7:0] SEL_TABLE   = 8'h10;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;    // 1 = level
        logic       pol;     // 1 = active low
        logic       dmode;   // 1 = logical destination
        logic [2:0] deliv;
        logic [7:0] vec;
    } rte_cfg_t;

    typedef struct packed {
        logic [7:0] vec;
        logic [7:0] dest;
        logic       dmode;
        logic [2:0] deliv;
        logic       trig;
    } irq_msg_t;

    typedef enum logic [1:0] {
        WIN_SEL_ID,
        WIN_SEL_FIXED,
        WIN_SEL_TABLE,
        WIN_SEL_NONE
    } win_kind_e;

    localparam rte_cfg_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                       pol: 1'b0, dmode: 1'b0, deliv: 3'b000,
                                       vec: 8'h00};

    function automatic logic [31:0] rte_lo_word(rte_cfg_t c, logic rirr, logic pend);
        return {15'd0, c.mask, c.trig, rirr & c.trig, c.pol, pend,
                c.dmode, c.deliv, c.vec};
    endfunction

    function automatic logic [31:0] rte_hi_word(rte_cfg_t c);
        return {c.dest, 24'd0};
    endfunction

    function automatic rte_cfg_t rte_put_lo(rte_cfg_t c, logic [31:0] w);
        rte_cfg_t r;
        r       = c;
        r.mask  = w[16];
        r.trig  = w[15];
        r.pol   = w[13];
        r.dmode = w[11];
        r.deliv = w[10:8];
        r.vec   = w[7:0];
        return r;
    endfunction

    function automatic rte_cfg_t rte_put_hi(rte_cfg_t c, logic [31:0] w);
        rte_cfg_t r;
        r      = c;
        r.dest = w[31:24];
        return r;
    endfunction

    function automatic irq_msg_t rte_to_msg(rte_cfg_t c);
        irq_msg_t m;
        m.vec   = c.vec;
        m.dest  = c.dest;
        m.dmode = c.dmode;
        m.deliv = c.deliv;
        m.trig  = c.trig;
        return m;
    endfunction

endpackage

// File: rtl/irt_regfile.sv
module irt_regfile
    import irt_pkg::*;
#(
    parameter int N_IRQ  = 24,
    parameter int ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic [N_IRQ-1:0]       rirr_i,
    input  logic [N_IRQ-1:0]       pend_i,
    output rte_cfg_t [N_IRQ-1:0]   cfg_o
);
    localparam int                ENT_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(8'h10);
    localparam int                TBL_END  = 16 + 2 * N_IRQ;
    localparam logic [31:0]       VERSION  = {8'h00, 8'(N_IRQ - 1), 8'h00, 8'h11};

    logic [7:0]           sel_q;
    logic [3:0]           id_q;
    rte_cfg_t [N_IRQ-1:0] cfg_q;

    logic       sel_wr, win_wr, tbl_hit, half_hi;
    logic [7:0] tbl_off;
    logic [ENT_W-1:0] ent;
    win_kind_e  kind;

    assign sel_wr  = wr_en && (addr == OFF_SEL) && be[0];
    assign win_wr  = wr_en && (addr == OFF_WIN) && (be == 4'hF);
    assign tbl_off = sel_q - SEL_TABLE;
    assign tbl_hit = (int'(sel_q) >= 16) && (int'(sel_q) < TBL_END);
    assign half_hi = tbl_off[0];
    assign ent     = ENT_W'(tbl_off[7:1]);

    always_comb begin
        if (sel_q == SEL_ID)                                kind = WIN_SEL_ID;
        else if (sel_q == SEL_VERSION || sel_q == SEL_ARB)  kind = WIN_SEL_FIXED;
        else if (tbl_hit)                                   kind = WIN_SEL_TABLE;
        else                                                kind = WIN_SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 8'h00;
            id_q  <= 4'h0;
        end else begin
            if (sel_wr) sel_q <= wdata[7:0];
            if (win_wr && kind == WIN_SEL_ID) id_q <= wdata[27:24];
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= RTE_RESET;
            end else if (win_wr && kind == WIN_SEL_TABLE && int'(ent) == i) begin
                cfg_q[i] <= half_hi ? rte_put_hi(cfg_q[i], wdata)
                                    : rte_put_lo(cfg_q[i], wdata);
            end
        end
    end

    logic [31:0] win_data;
    always_comb begin
        case (kind)
            WIN_SEL_ID:    win_data = {4'h0, id_q, 24'h0};
            WIN_SEL_FIXED: win_data = (sel_q == SEL_VERSION) ? VERSION : 32'h0;
            WIN_SEL_TABLE: win_data = half_hi ? rte_hi_word(cfg_q[ent])
                                              : rte_lo_word(cfg_q[ent], rirr_i[ent], pend_i[ent]);
            default:       win_data = 32'h0;
        endcase
    end

    always_comb begin
        if (addr == OFF_SEL)      rdata = {24'h0, sel_q};
        else if (addr == OFF_WIN) rdata = win_data;
        else                      rdata = 32'h0;
    end

    assign cfg_o = cfg_q;

    p_partial_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_WIN && be != 4'hF) |=> ($stable(cfg_q) && $stable(id_q)));

endmodule

// File: rtl/irt_input_stage.sv
module irt_input_stage
    import irt_pkg::*;
#(
    parameter int N_IRQ = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IRQ-1:0]     irq_raw,
    input  rte_cfg_t [N_IRQ-1:0] cfg_i,
    output logic [N_IRQ-1:0]     edge_evt,
    output logic [N_IRQ-1:0]     lvl_act
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic raw_q, act, act_q;

        assign act = raw_q ^ cfg_i[i].pol;

        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q <= 1'b0;
                act_q <= 1'b0;
            end else begin
                raw_q <= irq_raw[i];
                act_q <= act;
            end
        end

        assign edge_evt[i] = act & ~act_q;
        assign lvl_act[i]  = act;
    end
endmodule

// File: rtl/irt_dispatch.sv
module irt_dispatch
    import irt_pkg::*;
#(
    parameter int N_IRQ = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rte_cfg_t [N_IRQ-1:0] cfg_i,
    input  logic [N_IRQ-1:0]     edge_evt,
    input  logic [N_IRQ-1:0]     lvl_act,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vec,
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output irq_msg_t             msg_o,
    output logic [N_IRQ-1:0]     pend_o,
    output logic [N_IRQ-1:0]     rirr_o
);
    localparam int ENT_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic [N_IRQ-1:0] pend_q, rirr_q, mask_v, offer, taken;
    logic             hold_v;
    logic [ENT_W-1:0] hold_idx, pick;
    irq_msg_t         hold_msg;
    logic             accept;

    assign accept = hold_v && msg_ready;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_ent
        logic set_edge, set_lvl, eoi_hit;

        assign mask_v[i] = cfg_i[i].mask;
        assign taken[i]  = accept && (int'(hold_idx) == i);
        assign set_edge  = edge_evt[i] && !cfg_i[i].trig && !cfg_i[i].mask;
        assign set_lvl   = lvl_act[i] && cfg_i[i].trig && !cfg_i[i].mask && !rirr_q[i];
        assign eoi_hit   = eoi_valid && (eoi_vec == cfg_i[i].vec);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
                rirr_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= set_edge || ((pend_q[i] || set_lvl) && !taken[i]);
                if (taken[i] && hold_msg.trig) rirr_q[i] <= 1'b1;
                else if (eoi_hit || !cfg_i[i].trig) rirr_q[i] <= 1'b0;
            end
        end
    end

    assign offer = pend_q & ~mask_v;

    always_comb begin
        pick = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (offer[i]) pick = ENT_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_idx <= '0;
            hold_msg <= '0;
        end else if (accept) begin
            hold_v <= 1'b0;
        end else if (!hold_v && |offer) begin
            hold_v   <= 1'b1;
            hold_idx <= pick;
            hold_msg <= rte_to_msg(cfg_i[pick]);
        end
    end

    assign msg_valid = hold_v;
    assign msg_o     = hold_msg;
    assign pend_o    = pend_q;
    assign rirr_o    = rirr_q;

    p_hold_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_o)));

    p_status_while_held_r11: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> pend_q[hold_idx]);

    p_rirr_after_level_r10: assert property (@(posedge clk) disable iff (rst)
        (accept && hold_msg.trig) |=> rirr_q[$past(hold_idx)]);

    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(mask_v & ~pend_q)) == '0));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
    import irt_pkg::*;
#(
    parameter int N_IRQ  = 24,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest,
    output logic              msg_dest_logical,
    output logic [2:0]        msg_deliv_mode,
    output logic              msg_level,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector
);
    rte_cfg_t [N_IRQ-1:0] cfg;
    logic [N_IRQ-1:0]     pend, rirr, edge_evt, lvl_act;
    irq_msg_t             msg;

    irt_regfile #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .be(reg_be),
        .wdata(reg_wdata), .rdata(reg_rdata), .rirr_i(rirr), .pend_i(pend),
        .cfg_o(cfg)
    );

    irt_input_stage #(.N_IRQ(N_IRQ)) u_inputs (
        .clk(clk), .rst(rst), .irq_raw(irq_in), .cfg_i(cfg),
        .edge_evt(edge_evt), .lvl_act(lvl_act)
    );

    irt_dispatch #(.N_IRQ(N_IRQ)) u_disp (
        .clk(clk), .rst(rst), .cfg_i(cfg), .edge_evt(edge_evt), .lvl_act(lvl_act),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vector), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_o(msg), .pend_o(pend), .rirr_o(rirr)
    );

    assign msg_vector       = msg.vec;
    assign msg_dest         = msg.dest;
    assign msg_dest_logical = msg.dmode;
    assign msg_deliv_mode   = msg.deliv;
    assign msg_level        = msg.trig;

endmodule

// File: tb/irq_redirect_ctrl_bench.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [23:0] irq_in = 24'h0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic        msg_dest_logical, msg_level;
    logic [2:0]  msg_deliv_mode;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = 8'h0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_redirect_ctrl u_irq_redirect_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
        .msg_deliv_mode(msg_deliv_mode), .msg_level(msg_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo(bit m, bit t, bit p, bit dm, logic [2:0] d, logic [7:0] v);
        return {15'd0, m, t, 1'b0, p, 1'b0, dm, d, v};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_win(input logic [7:0] sel, input logic [31:0] d, input logic [3:0] be);
        wr(5'h00, {24'h0, sel}, 4'h1);
        wr(5'h10, d, be);
    endtask

    task automatic rd_win(input logic [7:0] sel, output logic [31:0] d);
        wr(5'h00, {24'h0, sel}, 4'h1);
        rd(5'h10, d);
    endtask

    task automatic wait_msg(input int lim, output bit seen);
        seen = 0;
        for (int k = 0; k < lim && !seen; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
    endtask

    task automatic take;
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h00, d);        check("R1 selector", d, 32'h0);
        check("R1 no msg", {31'd0, msg_valid}, 32'h0);
        rd(5'h10, d);        check("R1 id word", d, 32'h0);
        rd_win(8'h10, d);    check("R1 entry0 lo", d, 32'h0001_0000);
        rd_win(8'h3F, d);    check("R1 entry23 hi", d, 32'h0);
    endtask

    task automatic t_access;
        logic [31:0] d;
        wr(5'h00, 32'hFFFF_FF5A, 4'h1);
        rd(5'h00, d);        check("R2 selector readback", d, 32'h0000_005A);
        wr_win(8'h00, 32'hFFFF_FFFF, 4'hF);
        rd(5'h10, d);        check("R4 id bits", d, 32'h0F00_0000);
        rd_win(8'h01, d);    check("R4 version", d, 32'h0017_0011);
        wr_win(8'h01, 32'h0, 4'hF);
        rd_win(8'h01, d);    check("R4 version ro", d, 32'h0017_0011);
        wr_win(8'h02, 32'hFFFF_FFFF, 4'hF);
        rd_win(8'h02, d);    check("R4 arb id", d, 32'h0);
        wr_win(8'h12, 32'h0000_00AB, 4'h7);
        rd(5'h10, d);        check("R3 partial write", d, 32'h0001_0000);
        wr_win(8'h12, 32'hFFFF_FFFF, 4'hF);
        rd(5'h10, d);        check("R5 lo fields", d, 32'h0001_AFFF);
        wr_win(8'h13, 32'hFFFF_FFFF, 4'hF);
        rd(5'h10, d);        check("R5 hi fields", d, 32'hFF00_0000);
        wr_win(8'h12, 32'h0001_0000, 4'hF);
        wr_win(8'h13, 32'h0, 4'hF);
        wr_win(8'h40, 32'hFFFF_FFFF, 4'hF);
        rd(5'h10, d);        check("R6 reserved reads 0", d, 32'h0);
        rd_win(8'h3E, d);    check("R6 last entry untouched", d, 32'h0001_0000);
        rd_win(8'h10, d);    check("R6 first entry untouched", d, 32'h0001_0000);
    endtask

    task automatic t_edge;
        bit seen;
        wr_win(8'h12, lo(0, 0, 0, 0, 3'b000, 8'h21), 4'hF);
        @(negedge clk); irq_in[1] = 1'b1;
        wait_msg(6, seen);
        check("R7 edge delivers", {31'd0, seen}, 32'h1);
        check("R7 vector", {24'd0, msg_vector}, 32'h21);
        check("R13 edge trigger flag", {31'd0, msg_level}, 32'h0);
        take;
        wait_msg(8, seen);
        check("R7 held line no repeat", {31'd0, seen}, 32'h0);
        irq_in[1] = 1'b0;
        irq_in[2] = 1'b1;
        wr_win(8'h14, lo(0, 0, 1, 0, 3'b000, 8'h22), 4'hF);
        wait_msg(6, seen);
        check("R8 high level idle for active low", {31'd0, seen}, 32'h0);
        irq_in[2] = 1'b0;
        wait_msg(6, seen);
        check("R8 falling edge delivers", {31'd0, seen}, 32'h1);
        check("R8 vector", {24'd0, msg_vector}, 32'h22);
        take;
    endtask

    task automatic t_masked;
        bit seen;
        wr_win(8'h18, lo(1, 0, 0, 0, 3'b000, 8'h44), 4'hF);
        @(negedge clk); irq_in[4] = 1'b1;
        wait_msg(6, seen);
        check("R9 masked edge", {31'd0, seen}, 32'h0);
        wr_win(8'h18, lo(0, 0, 0, 0, 3'b000, 8'h44), 4'hF);
        wait_msg(8, seen);
        check("R9 not latched", {31'd0, seen}, 32'h0);
        irq_in[4] = 1'b0;
    endtask

    task automatic t_level;
        bit seen;
        logic [31:0] d;
        wr_win(8'h16, lo(0, 1, 0, 0, 3'b000, 8'h33), 4'hF);
        @(negedge clk); irq_in[3] = 1'b1;
        wait_msg(6, seen);
        check("R10 level delivers", {31'd0, seen}, 32'h1);
        check("R13 level trigger flag", {31'd0, msg_level}, 32'h1);
        rd_win(8'h16, d);
        check("R11 status while waiting", d, 32'h0000_9033);
        check("R12 still offered", {31'd0, msg_valid}, 32'h1);
        take;
        rd(5'h10, d);
        check("R11 status cleared, R10 rirr set", d, 32'h0000_C033);
        wait_msg(8, seen);
        check("R10 no repeat before eoi", {31'd0, seen}, 32'h0);
        send_eoi(8'h44);
        wait_msg(8, seen);
        check("R10 wrong vector eoi", {31'd0, seen}, 32'h0);
        rd(5'h10, d);
        check("R10 rirr kept", d, 32'h0000_C033);
        send_eoi(8'h33);
        wait_msg(8, seen);
        check("R10 redeliver after eoi", {31'd0, seen}, 32'h1);
        take;
        irq_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        send_eoi(8'h33);
        wait_msg(8, seen);
        check("R10 inactive after eoi", {31'd0, seen}, 32'h0);
        rd(5'h10, d);
        check("R10 rirr cleared", d, 32'h0000_8033);
    endtask

    task automatic t_priority;
        bit seen;
        wr_win(8'h1E, lo(0, 0, 0, 0, 3'b001, 8'h77), 4'hF);
        wr_win(8'h1A, lo(0, 0, 0, 1, 3'b100, 8'h55), 4'hF);
        wr_win(8'h1B, 32'hA500_0000, 4'hF);
        @(negedge clk); irq_in[5] = 1'b1; irq_in[7] = 1'b1;
        wait_msg(6, seen);
        check("R12 lowest first", {24'd0, msg_vector}, 32'h55);
        check("R13 dest", {24'd0, msg_dest}, 32'hA5);
        check("R13 dest mode", {31'd0, msg_dest_logical}, 32'h1);
        check("R13 delivery mode", {29'd0, msg_deliv_mode}, 32'h4);
        repeat (4) @(negedge clk);
        check("R12 held valid", {31'd0, msg_valid}, 32'h1);
        check("R12 held vector", {24'd0, msg_vector}, 32'h55);
        take;
        wait_msg(6, seen);
        check("R12 second entry", {24'd0, msg_vector}, 32'h77);
        check("R13 second delivery mode", {29'd0, msg_deliv_mode}, 32'h1);
        take;
        wait_msg(6, seen);
        check("R12 queue drained", {31'd0, seen}, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_access;
        t_edge;
        t_masked;
        t_level;
        t_priority;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run;
    end
endmodule